// File: doc/BRIEF.md
# Serial Link FIFO Pair with Sticky Error Status

This block sits between a host bus and a word-level serial engine. It holds a transmit queue and a receive queue, each 16 words of 32 bits. The host pushes outgoing words with a write strobe. The serial engine takes them one at a time with a load strobe. In the other direction, the serial engine pushes incoming words and the host drains them with a read strobe. The bit shifter, frame timing and clock generation are not part of this block. They appear here only as the load and push strobes.

Three misuse conditions are recorded as sticky status flags:
- a host write into a full transmit queue;
- a serial load from an empty transmit queue;
- a host read from an empty receive queue.

The host clears a flag by writing 1 to its bit. Each flag has an interrupt enable, and the enabled flags are combined into one interrupt line. When the transmit queue runs dry, the outgoing word stays at the last word sent. The serial side therefore repeats that word instead of sending zeros.

Top module: `serial_fifo_pair`

## Requirements
- R1: Words written by the host leave on `ser_tx_data` in write order. A word appears one cycle after the `ser_load` pulse that takes it. The transmit queue reports full after 16 accepted writes and empty after they have all been loaded.
- R2: A host write while the transmit queue is full is discarded and leaves the queued words unchanged. If `tx_en` is 1, the write also sets status bit 3 (transmit overflow).
- R3: A `ser_load` while the transmit queue is empty leaves `ser_tx_data` at the previously sent word, which is zero after reset. If `tx_en` is 1, the load also sets status bit 2 (transmit underflow).
- R4: A host read while the receive queue is empty sets status bit 1 (receive underflow) if `rx_en` is 1. The receive queue pointers do not move, so a word pushed afterwards is the next one read.
- R5: `stat_rdata` returns transmit overflow in bit 3, transmit underflow in bit 2 and receive underflow in bit 1. Bit 0 reads 0. A cycle with `stat_wr` high clears every flag whose bit in `stat_wdata` is 1. Bits written as 0 leave their flags unchanged.
- R6: While `tx_en` is 0, bits 2 and 3 are never set. While `rx_en` is 0, bit 1 is never set.
- R7: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when some status flag is 1 and the `irq_en` bit at the same position is 1.
- R9: Words pushed by the serial side are read by the host in push order. The head word is visible on `host_rd_data` before the read strobe. A push into a full receive queue (16 words) is dropped.
- R10: After reset both queues are empty, all flags are 0, `irq` is 0 and `ser_tx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; gates the two transmit flags |
| rx_en | input | 1 | Receive enable; gates the receive flag |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 32 | Host write word |
| host_rd | input | 1 | Host read strobe from the receive queue |
| host_rd_data | output | 32 | Head word of the receive queue |
| ser_load | input | 1 | Serial side takes the next transmit word |
| ser_tx_data | output | 32 | Word currently being sent |
| ser_push | input | 1 | Serial side delivers a received word |
| ser_rx_data | input | 32 | Received word |
| stat_wr | input | 1 | Write-1-to-clear strobe for the status flags |
| stat_wdata | input | 4 | Clear mask, same bit layout as `stat_rdata` |
| stat_rdata | output | 4 | Status flags |
| irq_en | input | 4 | Interrupt enables, same bit layout as `stat_rdata` |
| irq | output | 1 | Interrupt request |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |

## Verification
A corrupted queue pointer appears at the ports within one strobe. It can show as a full or empty indication at the wrong fill level, as a word out of order on `ser_tx_data` or `host_rd_data`, or as an overflow word that shows up after the queue is drained. A flag register that misses a set, a gate or a clear shows up in `stat_rdata` and `irq` on the cycle after the event. A last-sent register that follows the empty queue shows up as a changed `ser_tx_data` one cycle after an underflowing load.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int STAT_W     = 4;
  localparam int BIT_TX_OVF = 3;
  localparam int BIT_TX_UDF = 2;
  localparam int BIT_RX_UDF = 1;

  // Occupancy from pointers that carry one extra wrap bit.
  function automatic int unsigned ptr_count(int unsigned wp, int unsigned rp,
                                            int unsigned aw);
    int unsigned mask;
    mask = (32'd1 << (aw + 1)) - 32'd1;
    return (wp - rp) & mask;
  endfunction

  // Clear-mask merge: a set in the same cycle overrides the clear.
  function automatic logic [STAT_W-1:0] flag_next(logic [STAT_W-1:0] cur,
                                                  logic [STAT_W-1:0] set,
                                                  logic [STAT_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  int unsigned   count;
  logic          push_ok, pop_ok;

  assign count     = sfp_pkg::ptr_count(32'(wptr), 32'(rptr), AW);
  assign full      = (count == 32'(DEPTH));
  assign empty     = (count == 32'd0);
  assign push_ok   = push & ~full;
  assign pop_ok    = pop & ~empty;
  assign push_drop = push & full;
  assign pop_empty = pop & empty;
  assign head      = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
    end
  end

  // R2 / R9: a dropped push leaves the write pointer where it was
  a_r2_drop_holds_wptr: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> (wptr == $past(wptr)));
  // R4: a pop on empty leaves the read pointer where it was
  a_r4_empty_pop_holds_rptr: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> (rptr == $past(rptr)));
  // R1: full and empty never coincide
  a_r1_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/sfp_err_status.sv
module sfp_err_status #(
  parameter int W = sfp_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] gate,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] irq_en,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] set_g, clr_g;

  assign set_g = set_ev & gate;
  assign clr_g = clr_we ? clr_mask : '0;
  assign irq   = |(flags & irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= sfp_pkg::flag_next(flags, set_g, clr_g);
  end

  for (genvar k = 0; k < W; k++) begin : g_chk
    // R7: a gated set event always leaves the flag at 1
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev[k] && gate[k]) |=> flags[k]);
    // R5: a clear with no set leaves the flag at 0
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[k] && !(set_ev[k] && gate[k])) |=> !flags[k]);
    // R6: a closed gate never raises a flag
    a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate[k] && !flags[k]) |=> !flags[k]);
  end
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rd_data,
  input  logic          ser_load,
  output logic [DW-1:0] ser_tx_data,
  input  logic          ser_push,
  input  logic [DW-1:0] ser_rx_data,
  input  logic          stat_wr,
  input  logic [3:0]    stat_wdata,
  output logic [3:0]    stat_rdata,
  input  logic [3:0]    irq_en,
  output logic          irq,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty
);
  import sfp_pkg::*;

  logic [DW-1:0]     tx_head, last_sent;
  logic              tx_ovf_ev, tx_udf_ev, rx_udf_ev, rx_drop_ev;
  logic [STAT_W-1:0] set_ev, gate;

  sfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(host_wr), .push_data(host_wdata),
    .pop(ser_load), .head(tx_head),
    .full(tx_full), .empty(tx_empty),
    .push_drop(tx_ovf_ev), .pop_empty(tx_udf_ev)
  );

  sfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(ser_push), .push_data(ser_rx_data),
    .pop(host_rd), .head(host_rd_data),
    .full(rx_full), .empty(rx_empty),
    .push_drop(rx_drop_ev), .pop_empty(rx_udf_ev)
  );

  always_comb begin
    set_ev             = '0;
    gate               = '0;
    set_ev[BIT_TX_OVF] = tx_ovf_ev;
    set_ev[BIT_TX_UDF] = tx_udf_ev;
    set_ev[BIT_RX_UDF] = rx_udf_ev;
    gate[BIT_TX_OVF]   = tx_en;
    gate[BIT_TX_UDF]   = tx_en;
    gate[BIT_RX_UDF]   = rx_en;
  end

  sfp_err_status #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_ev(set_ev), .gate(gate),
    .clr_we(stat_wr), .clr_mask(stat_wdata),
    .irq_en(irq_en), .flags(stat_rdata), .irq(irq)
  );

  // Last-sent word: replaced only by a load that finds data
  always_ff @(posedge clk) begin
    if (!rst_n)                     last_sent <= '0;
    else if (ser_load && !tx_empty) last_sent <= tx_head;
  end
  assign ser_tx_data = last_sent;

  // R3: an underflowing load repeats the previous word
  a_r3_udf_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_load && tx_empty) |=> $stable(ser_tx_data));
  // R9: a dropped receive push leaves the queue full
  a_r9_rx_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop_ev && !host_rd) |=> rx_full);
  // R5: status bit 0 never becomes 1
  a_r5_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdata[0]);
endmodule

// File: tb/serial_fifo_pair_tb.sv
module serial_fifo_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0, rx_en = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, ser_load = 1'b0, ser_push = 1'b0;
  logic [31:0] host_wdata = '0, ser_rx_data = '0;
  logic        stat_wr = 1'b0;
  logic [3:0]  stat_wdata = '0, irq_en = '0;
  logic [31:0] host_rd_data, ser_tx_data;
  logic [3:0]  stat_rdata;
  logic        irq, tx_full, tx_empty, rx_full, rx_empty;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rd_data(host_rd_data),
    .ser_load(ser_load), .ser_tx_data(ser_tx_data),
    .ser_push(ser_push), .ser_rx_data(ser_rx_data),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .irq_en(irq_en), .irq(irq),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock; returns 1 ns after the edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_tx(logic [31:0] d);
    host_wr = 1'b1; host_wdata = d; tick(); host_wr = 1'b0;
  endtask
  task automatic load();
    ser_load = 1'b1; tick(); ser_load = 1'b0;
  endtask
  task automatic push_rx(logic [31:0] d);
    ser_push = 1'b1; ser_rx_data = d; tick(); ser_push = 1'b0;
  endtask
  task automatic rd_rx();
    host_rd = 1'b1; tick(); host_rd = 1'b0;
  endtask
  task automatic clr(logic [3:0] m);
    stat_wr = 1'b1; stat_wdata = m; tick(); stat_wr = 1'b0; stat_wdata = '0;
  endtask

  task automatic t_reset();
    chk("R10 tx_empty", 32'(tx_empty), 1);
    chk("R10 rx_empty", 32'(rx_empty), 1);
    chk("R10 status", 32'(stat_rdata), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 ser_tx_data", ser_tx_data, 0);
  endtask

  task automatic t_first_underflow();
    tx_en = 1'b1;
    load();
    chk("R3 data zero", ser_tx_data, 0);
    chk("R3 udf flag", 32'(stat_rdata), 32'h4);
    clr(4'h0);
    chk("R5 write 0 keeps", 32'(stat_rdata), 32'h4);
    clr(4'hB);
    chk("R5 other bits keep", 32'(stat_rdata), 32'h4);
    clr(4'h4);
    chk("R5 write 1 clears", 32'(stat_rdata), 32'h0);
  endtask

  task automatic t_tx_order();
    for (int i = 0; i < 16; i++) wr_tx(32'hA500_0000 + 32'(i));
    chk("R1 full at 16", 32'(tx_full), 1);
    chk("R2 no flag yet", 32'(stat_rdata), 0);
    wr_tx(32'hDEAD_BEEF);
    chk("R2 ovf flag", 32'(stat_rdata), 32'h8);
    chk("R2 still full", 32'(tx_full), 1);
    for (int i = 0; i < 16; i++) begin
      load();
      chk("R1 order", ser_tx_data, 32'hA500_0000 + 32'(i));
    end
    chk("R1 empty after drain", 32'(tx_empty), 1);
    chk("R2 no udf during drain", 32'(stat_rdata), 32'h8);
    load();
    chk("R3 repeat last", ser_tx_data, 32'hA500_000F);
    chk("R3 udf flag", 32'(stat_rdata), 32'hC);
    clr(4'hC);
  endtask

  task automatic t_gates();
    tx_en = 1'b0; rx_en = 1'b0;
    load();
    rd_rx();
    chk("R6 gated off", 32'(stat_rdata), 0);
    for (int i = 0; i < 17; i++) wr_tx(32'h100 + 32'(i));
    chk("R6 ovf gated", 32'(stat_rdata), 0);
    for (int i = 0; i < 16; i++) load();
    chk("R6 drained", 32'(tx_empty), 1);
    chk("R2 overflow word dropped", ser_tx_data, 32'h10F);
    tx_en = 1'b1; rx_en = 1'b1;
  endtask

  task automatic t_rx();
    for (int i = 0; i < 17; i++) push_rx(32'h5A00_0000 + 32'(i));
    chk("R9 full", 32'(rx_full), 1);
    for (int i = 0; i < 16; i++) begin
      chk("R9 order", host_rd_data, 32'h5A00_0000 + 32'(i));
      rd_rx();
    end
    chk("R9 extra push dropped", 32'(rx_empty), 1);
    rd_rx();
    chk("R4 rx udf flag", 32'(stat_rdata), 32'h2);
    push_rx(32'h1234_5678);
    chk("R4 pointers held", host_rd_data, 32'h1234_5678);
    rd_rx();
    chk("R4 empty again", 32'(rx_empty), 1);
    clr(4'h2);
  endtask

  task automatic t_set_wins();
    ser_load = 1'b1; stat_wr = 1'b1; stat_wdata = 4'h4;
    tick();
    ser_load = 1'b0; stat_wr = 1'b0; stat_wdata = '0;
    chk("R7 set beats clear", 32'(stat_rdata), 32'h4);
  endtask

  task automatic t_irq();
    irq_en = 4'h0; #1;
    chk("R8 masked", 32'(irq), 0);
    irq_en = 4'h8; #1;
    chk("R8 other enable", 32'(irq), 0);
    irq_en = 4'h4; #1;
    chk("R8 enabled", 32'(irq), 1);
    clr(4'h4);
    chk("R8 cleared", 32'(irq), 0);
    irq_en = 4'h0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_first_underflow();
    t_tx_order();
    t_gates();
    t_rx();
    t_set_wins();
    t_irq();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule